// File: doc/BRIEF.md
# Configuration DMA Command Queue

This block is the command front end of a DMA engine that feeds a device configuration port. Software programs four holding fields through a simple register write port: the source address, the destination address, the source length and the destination length. Writing the destination length field commits the command. A committed command is checked first. If it is valid it goes into a small queue. If it is invalid or the queue is full it is dropped, and a one-cycle event pulse reports why.

A streaming engine takes commands from the queue one at a time. It reads 32-bit words from a memory read port, starting at the word-aligned source address and stepping by four bytes, and hands each word to a ready/valid configuration data sink. Lengths count 4-byte words. Bit 0 of the source address flags the final transfer of a load. For such a transfer the engine waits until the configuration port reports that it has drained, and only then reports completion. A destination address of all ones means the stream has no destination.

Software sees queue full and queue empty flags. An interrupt block receives four event pulses. From bit 0 to bit 3 they are: configuration port done, DMA done, queue overflow and command error. These bits correspond to interrupt bits 12 to 15.

Top module: `cfg_dma_cmdq`

## Requirements
- R1: Writes to field selects 0 (source address), 1 (destination address) and 2 (source length) only update holding registers and enqueue nothing. A write to select 3 (destination length) commits a command built from the latest held values.
- R2: A transfer of N words issues N memory reads. The addresses start at the source address with bits [1:0] cleared and rise by 4 after each accepted word. Each word read goes to the sink, in order.
- R3: While snk_valid_o is high and snk_ready_i is low, snk_valid_o stays high and snk_data_o stays unchanged.
- R4: A command with source length 0 and destination 0xFFFFFFFF is accepted. It completes with a DMA done pulse and sends no words.
- R5: A command with source length above 0x7FFFFFF, or with source length 0 and a destination other than 0xFFFFFFFF, gives a one-cycle command error pulse on evt_o[3]. It is not queued.
- R6: A valid command committed while the queue is full is dropped, and evt_o[2] (overflow) pulses for one cycle.
- R7: q_full_o is high when DEPTH commands are waiting in the queue. q_empty_o is high when none are waiting. The two are never high together.
- R8: For a transfer whose source address bit 0 is 1, completion waits for port_idle_i. When it completes, evt_o[0] (port done) pulses together with evt_o[1].
- R9: Each transfer that completes gives exactly one one-cycle pulse on evt_o[1] (DMA done).
- R10: After reset the queue is empty, no request or sink valid is driven and no event is asserted.
- R11: While mem_req_o is high and mem_ack_i is low, the request and its address stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Field select: 0 src addr, 1 dst addr, 2 src len, 3 dst len (commit) |
| reg_wdata_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read byte address, word aligned |
| mem_ack_i | input | 1 | Read acknowledge, data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |
| snk_valid_o | output | 1 | Sink word valid |
| snk_data_o | output | 32 | Sink word |
| snk_ready_i | input | 1 | Sink ready |
| port_idle_i | input | 1 | Configuration port has drained |
| q_full_o | output | 1 | Command queue full (status bit 31) |
| q_empty_o | output | 1 | Command queue empty (status bit 30) |
| evt_o | output | 4 | Event pulses: [0] port done, [1] DMA done, [2] overflow, [3] command error |

## Verification
The bench runs a table of commands: aligned and misaligned sources, several lengths, zero-length commands with and without a destination, lengths over the limit, and a destination given with a nonzero length. Together these separate accepted streams from rejected ones and check the address alignment rule. The memory model returns an address-derived word and acknowledges irregularly, and the sink stalls in its own pattern. Any wrong address, dropped word or reordered word therefore shows up as a data mismatch. Directed tests cover commit-only-on-the-last-field, the wait for the port to drain before reporting done, and filling the queue past full so that exactly one command is dropped.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LEN_W  = 27;
  localparam int unsigned WA_W   = DATA_W - 2;

  localparam logic [1:0] SEL_SRC_ADDR = 2'd0;
  localparam logic [1:0] SEL_DST_ADDR = 2'd1;
  localparam logic [1:0] SEL_SRC_LEN  = 2'd2;
  localparam logic [1:0] SEL_DST_LEN  = 2'd3;

  localparam int unsigned EVT_PORT_DONE = 0;
  localparam int unsigned EVT_DMA_DONE  = 1;
  localparam int unsigned EVT_OVF       = 2;
  localparam int unsigned EVT_CMD_ERR   = 3;
  localparam int unsigned EVT_W         = 4;

  typedef struct packed {
    logic [WA_W-1:0]  word_addr;
    logic             last;
    logic [LEN_W-1:0] len;
  } cmd_t;

  localparam int unsigned CMD_W = $bits(cmd_t);

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_PUSH  = 2'd2,
    S_FIN   = 2'd3
  } eng_state_e;
endpackage

// File: rtl/cfg_dma_regs.sv
module cfg_dma_regs
  import cfg_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              full_i,
  output logic              push_o,
  output cmd_t              cmd_o,
  output logic              err_o,
  output logic              ovf_o
);
  logic [WA_W-1:0]  src_word_q;
  logic             src_last_q;
  logic             dst_none_q;
  logic [LEN_W-1:0] len_q;
  logic             len_big_q;
  logic             commit, bad;
  logic             err_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_word_q <= '0;
      src_last_q <= 1'b0;
      dst_none_q <= 1'b0;
      len_q      <= '0;
      len_big_q  <= 1'b0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_SRC_ADDR: begin
          src_word_q <= wdata_i[DATA_W-1:2];
          src_last_q <= wdata_i[0];
        end
        SEL_DST_ADDR: dst_none_q <= &wdata_i;
        SEL_SRC_LEN: begin
          len_q     <= wdata_i[LEN_W-1:0];
          len_big_q <= |wdata_i[DATA_W-1:LEN_W];
        end
        default: ; // destination length: commit only
      endcase
    end
  end

  assign commit = we_i && (sel_i == SEL_DST_LEN);
  assign bad    = len_big_q || ((len_q == '0) && !dst_none_q);
  assign push_o = commit && !bad && !full_i;

  assign cmd_o.word_addr = src_word_q;
  assign cmd_o.last      = src_last_q;
  assign cmd_o.len       = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      err_q <= commit && bad;
      ovf_q <= commit && !bad && full_i;
    end
  end

  assign err_o = err_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/cfg_dma_fifo.sv
module cfg_dma_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (do_push && (wr_q == AW'(i))) mem_q[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              empty_i,
  input  cmd_t              cmd_i,
  output logic              pop_o,
  output logic              mem_req_o,
  output logic [DATA_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              snk_valid_o,
  output logic [DATA_W-1:0] snk_data_o,
  input  logic              snk_ready_i,
  input  logic              port_idle_i,
  output logic              dma_done_o,
  output logic              port_done_o
);
  eng_state_e        state_q;
  logic [WA_W-1:0]   addr_q;
  logic [LEN_W-1:0]  left_q;
  logic              last_q;
  logic [DATA_W-1:0] data_q;
  logic              finish;

  assign pop_o  = (state_q == S_IDLE) && !empty_i;
  assign finish = (state_q == S_FIN) && (!last_q || port_idle_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      last_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (!empty_i) begin
          addr_q  <= cmd_i.word_addr;
          left_q  <= cmd_i.len;
          last_q  <= cmd_i.last;
          state_q <= (cmd_i.len == '0) ? S_FIN : S_FETCH;
        end
        S_FETCH: if (mem_ack_i) begin
          data_q  <= mem_rdata_i;
          state_q <= S_PUSH;
        end
        S_PUSH: if (snk_ready_i) begin
          addr_q  <= addr_q + 1'b1;
          left_q  <= left_q - 1'b1;
          state_q <= (left_q == LEN_W'(1)) ? S_FIN : S_FETCH;
        end
        S_FIN: if (finish) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == S_FETCH);
  assign mem_addr_o  = {addr_q, 2'b00};
  assign snk_valid_o = (state_q == S_PUSH);
  assign snk_data_o  = data_q;
  assign dma_done_o  = finish;
  assign port_done_o = finish && last_q;
endmodule

// File: rtl/cfg_dma_cmdq.sv
module cfg_dma_cmdq
  import cfg_dma_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              snk_valid_o,
  output logic [31:0]       snk_data_o,
  input  logic              snk_ready_i,
  input  logic              port_idle_i,
  output logic              q_full_o,
  output logic              q_empty_o,
  output logic [3:0]        evt_o
);
  cmd_t push_cmd, head_cmd;
  logic push, pop, err, ovf, dma_done, port_done;

  cfg_dma_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .full_i  (q_full_o),
    .push_o  (push),
    .cmd_o   (push_cmd),
    .err_o   (err),
    .ovf_o   (ovf)
  );

  cfg_dma_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (push_cmd),
    .pop_i   (pop),
    .rdata_o (head_cmd),
    .full_o  (q_full_o),
    .empty_o (q_empty_o)
  );

  cfg_dma_engine u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .empty_i     (q_empty_o),
    .cmd_i       (head_cmd),
    .pop_o       (pop),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .snk_valid_o (snk_valid_o),
    .snk_data_o  (snk_data_o),
    .snk_ready_i (snk_ready_i),
    .port_idle_i (port_idle_i),
    .dma_done_o  (dma_done),
    .port_done_o (port_done)
  );

  always_comb begin
    evt_o                = '0;
    evt_o[EVT_PORT_DONE] = port_done;
    evt_o[EVT_DMA_DONE]  = dma_done;
    evt_o[EVT_OVF]       = ovf;
    evt_o[EVT_CMD_ERR]   = err;
  end
endmodule

// File: rtl/cfg_dma_cmdq_chk.sv
module cfg_dma_cmdq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_ack_i,
  input logic        snk_valid_o,
  input logic [31:0] snk_data_o,
  input logic        snk_ready_i,
  input logic        port_idle_i,
  input logic        q_full_o,
  input logic        q_empty_o,
  input logic [3:0]  evt_o
);
  p_flags_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(q_full_o && q_empty_o));

  p_addr_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_snk_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snk_valid_o && !snk_ready_i) |=> (snk_valid_o && $stable(snk_data_o)));

  p_port_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[0] |-> (evt_o[1] && port_idle_i));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[1] |=> !evt_o[1]);

  p_ovf_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[2] |-> $past(q_full_o));
endmodule

bind cfg_dma_cmdq cfg_dma_cmdq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i),
  .snk_valid_o (snk_valid_o),
  .snk_data_o  (snk_data_o),
  .snk_ready_i (snk_ready_i),
  .port_idle_i (port_idle_i),
  .q_full_o    (q_full_o),
  .q_empty_o   (q_empty_o),
  .evt_o       (evt_o)
);

// File: tb/tb_cfg_dma_cmdq.sv
`timescale 1ns/1ps
module tb_cfg_dma_cmdq;
  localparam logic [31:0] KEY = 32'h5A5A_0F0F;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] len;
    logic        err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, NONE,         32'd5,          1'b0},
    '{32'h0000_2002, NONE,         32'd3,          1'b0},
    '{32'h0000_3000, NONE,         32'd0,          1'b0},
    '{32'h0000_4000, 32'h8000_0000, 32'd0,         1'b1},
    '{32'h0000_5000, NONE,         32'h0800_0000,  1'b1},
    '{32'h0000_6000, NONE,         32'd1,          1'b0},
    '{32'h0000_7000, 32'h1234_0000, 32'd2,         1'b0},
    '{32'h0000_9001, NONE,         32'd2,          1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        snk_valid, snk_ready = 1'b0;
  logic [31:0] snk_data;
  logic        port_idle = 1'b1;
  logic        q_full, q_empty;
  logic [3:0]  evt;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit stall = 1'b0;
  bit finished = 1'b0;
  logic [31:0] exp_addr = '0;
  int words = 0, bad_data = 0, n_done = 0, n_pdone = 0, n_ovf = 0, n_err = 0, n_req = 0;

  always #10 clk = ~clk;

  cfg_dma_cmdq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .snk_valid_o(snk_valid), .snk_data_o(snk_data), .snk_ready_i(snk_ready),
    .port_idle_i(port_idle), .q_full_o(q_full), .q_empty_o(q_empty), .evt_o(evt)
  );

  // Memory and sink models; decisions made at negedge apply at the next posedge.
  always @(negedge clk) begin
    cyc++;
    snk_ready = stall ? 1'b0 : ((cyc % 4) != 1);
    mem_ack   = mem_req && ((cyc % 3) != 2);
    mem_rdata = mem_addr ^ KEY;
    if (rst_n) begin
      if (mem_req) n_req++;
      if (snk_valid && snk_ready) begin
        if (snk_data !== (exp_addr ^ KEY)) bad_data++;
        exp_addr = exp_addr + 32'd4;
        words++;
      end
      if (evt[0]) n_pdone++;
      if (evt[1]) n_done++;
      if (evt[2]) n_ovf++;
      if (evt[3]) n_err++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    words = 0; bad_data = 0; n_done = 0; n_pdone = 0; n_ovf = 0; n_err = 0; n_req = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic commit(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l);
    wr(2'd0, s); wr(2'd1, d); wr(2'd2, l); wr(2'd3, 32'd0);
  endtask

  task automatic wait_end(input int target);
    for (int i = 0; i < 3000; i++) begin
      if ((n_done >= target) || (n_err > 0)) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 empty", 32'(q_empty), 32'd1);
    chk("R10 full", 32'(q_full), 32'd0);
    chk("R10 evt", 32'(evt), 32'd0);
    chk("R10 req/valid", {30'd0, mem_req, snk_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table of commands (R2, R4, R5, R8, R9)
    for (int v = 0; v < NV; v++) begin
      clr();
      exp_addr = VECS[v].src & ~32'd3;
      commit(VECS[v].src, VECS[v].dst, VECS[v].len);
      wait_end(1);
      chk($sformatf("R5 err v%0d", v), 32'(n_err), 32'(VECS[v].err));
      chk($sformatf("R9 done v%0d", v), 32'(n_done), VECS[v].err ? 32'd0 : 32'd1);
      chk($sformatf("R2 words v%0d", v), 32'(words), VECS[v].err ? 32'd0 : VECS[v].len);
      chk($sformatf("R2 data v%0d", v), 32'(bad_data), 32'd0);
      chk($sformatf("R8 pdone v%0d", v), 32'(n_pdone),
          32'(!VECS[v].err && VECS[v].src[0]));
      chk($sformatf("R7 empty v%0d", v), 32'(q_empty), 32'd1);
    end

    // R1: only the destination length write commits
    clr();
    wr(2'd0, 32'h0000_A000); wr(2'd1, NONE); wr(2'd2, 32'd4);
    repeat (6) @(negedge clk);
    chk("R1 no enqueue", 32'(q_empty), 32'd1);
    chk("R1 no reads", 32'(n_req), 32'd0);
    wr(2'd0, 32'h0000_A100);
    exp_addr = 32'h0000_A100;
    wr(2'd3, 32'd0);
    wait_end(1);
    chk("R1 commit words", 32'(words), 32'd4);
    chk("R1 latest addr", 32'(bad_data), 32'd0);

    // R8: final transfer waits for the port to drain
    clr();
    port_idle = 1'b0;
    exp_addr = 32'h0000_C000;
    commit(32'h0000_C001, NONE, 32'd1);
    repeat (60) @(negedge clk);
    chk("R8 word sent", 32'(words), 32'd1);
    chk("R8 no early done", 32'(n_done), 32'd0);
    port_idle = 1'b1;
    wait_end(1);
    chk("R8 done after idle", 32'(n_done), 32'd1);
    chk("R8 port done", 32'(n_pdone), 32'd1);

    // R6/R7: fill the queue while the sink stalls
    clr();
    stall = 1'b1;
    exp_addr = 32'h0000_B000;
    for (int k = 0; k < 5; k++) commit(32'h0000_B000 + 32'(4 * k), NONE, 32'd1);
    repeat (2) @(negedge clk);
    chk("R7 full", 32'(q_full), 32'd1);
    chk("R7 not empty", 32'(q_empty), 32'd0);
    chk("R6 no ovf yet", 32'(n_ovf), 32'd0);
    commit(32'h0000_B014, NONE, 32'd1);
    repeat (2) @(negedge clk);
    chk("R6 ovf pulse", 32'(n_ovf), 32'd1);
    chk("R6 still full", 32'(q_full), 32'd1);
    stall = 1'b0;
    wait_end(5);
    chk("R6 five done", 32'(n_done), 32'd5);
    chk("R6 five words", 32'(words), 32'd5);
    chk("R6 data order", 32'(bad_data), 32'd0);
    chk("R7 empty at end", 32'(q_empty), 32'd1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule